// File: doc/BRIEF.md
# Ordered Dial Sequence Lock

This block is a clocked state machine guarding a lock that opens only after three dial operations arrive in a fixed order. Each operation is a turn direction plus a dial number. A one-cycle valid strobe presents it. The block advances one step per correct operation. An operation that does not match the expected step throws progress away. Once the third step completes, the block holds its open output high until a relock pulse arrives.

The key is right to 13, then left to 22, then right to 3. The order is part of the key: the same three operations in any other order leave the lock shut. The current step is brought out as a 2-bit code for debug. Position sensing, debouncing and the actuator driver sit outside the block.

Top module: `seq_lock`

## Requirements
- R1: A synchronous active-high reset puts the machine in the idle state, with `state_o` = 0 and `open_o` = 0.
- R2: A dial operation is sampled only on a rising clock edge where `op_valid_i` is 1. With `op_valid_i` low, the state does not change.
- R3: From idle, an operation with `dir_i` = 1 (right) and `value_i` = 13 moves the machine to the first-step state, code 1.
- R4: From the first-step state, `dir_i` = 0 (left) with `value_i` = 22 moves the machine to the second-step state, code 2.
- R5: From the second-step state, `dir_i` = 1 with `value_i` = 3 moves the machine to the open state, code 3.
- R6: In any state other than open, an operation that does not match the expected step returns the machine to idle (code 0). The exception is a mismatching operation that is right-13: it moves the machine to the first-step state (code 1).
- R7: Presenting the three key operations in any other order does not open the lock.
- R8: `open_o` is 1 exactly when the state is open (code 3), and 0 in the other three states.
- R9: In the open state, dial operations are ignored. A `relock_i` pulse (1 on a rising edge) returns the machine to idle. Outside the open state, `relock_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | One-cycle strobe marking a dial operation |
| dir_i | input | 1 | Turn direction, 1 = right, 0 = left |
| value_i | input | 6 | Dial number, unsigned |
| relock_i | input | 1 | Relock request, honoured only while open |
| open_o | output | 1 | Lock open flag |
| state_o | output | 2 | Step code: 0 idle, 1 first step, 2 second step, 3 open |

## Verification
Every result is registered once. A strobe or relock sampled at a rising edge therefore shows on `state_o` and `open_o` directly after that edge, and on no earlier edge. The bench drives inputs on falling edges. It samples the outputs on the next falling edge, half a period after the edge that took the stimulus. Idle cycles are inserted and sampled as well, so a state that changes without a strobe is caught.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
  localparam int VAL_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP1 = 2'd1,
    ST_STEP2 = 2'd2,
    ST_OPEN  = 2'd3
  } lock_st_e;

  typedef struct packed {
    logic             right;
    logic [VAL_W-1:0] val;
  } dial_op_t;

  function automatic logic op_is(dial_op_t op, logic r, logic [VAL_W-1:0] v);
    return (op.right == r) && (op.val == v);
  endfunction
endpackage

// File: rtl/seq_lock_match.sv
module seq_lock_match
  import seq_lock_pkg::*;
#(
  parameter logic [VAL_W-1:0] KEY0_VAL = 6'd13,
  parameter logic             KEY0_DIR = 1'b1,
  parameter logic [VAL_W-1:0] KEY1_VAL = 6'd22,
  parameter logic             KEY1_DIR = 1'b0,
  parameter logic [VAL_W-1:0] KEY2_VAL = 6'd3,
  parameter logic             KEY2_DIR = 1'b1
) (
  input  lock_st_e state_i,
  input  dial_op_t op_i,
  output logic     step_ok_o,
  output logic     is_first_o
);
  always_comb begin
    is_first_o = op_is(op_i, KEY0_DIR, KEY0_VAL);
    unique case (state_i)
      ST_IDLE:  step_ok_o = is_first_o;
      ST_STEP1: step_ok_o = op_is(op_i, KEY1_DIR, KEY1_VAL);
      ST_STEP2: step_ok_o = op_is(op_i, KEY2_DIR, KEY2_VAL);
      default:  step_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_lock_next.sv
module seq_lock_next
  import seq_lock_pkg::*;
(
  input  lock_st_e state_i,
  input  logic     valid_i,
  input  logic     relock_i,
  input  logic     step_ok_i,
  input  logic     is_first_i,
  output lock_st_e next_o,
  output logic     advance_o,
  output logic     fail_o
);
  always_comb begin
    next_o    = state_i;
    advance_o = 1'b0;
    fail_o    = 1'b0;
    if (state_i == ST_OPEN) begin
      if (relock_i) next_o = ST_IDLE;
    end else if (valid_i) begin
      if (step_ok_i) begin
        advance_o = 1'b1;
        next_o    = lock_st_e'(state_i + 2'd1);
      end else begin
        fail_o = 1'b1;
        next_o = is_first_i ? ST_STEP1 : ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             op_valid_i,
  input  logic             dir_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic             relock_i,
  output logic             open_o,
  output logic [1:0]       state_o
);
  lock_st_e state_q, state_d;
  dial_op_t op;
  logic     step_ok, is_first, advance, fail;

  assign op = '{right: dir_i, val: value_i};

  seq_lock_match u_match (
    .state_i   (state_q),
    .op_i      (op),
    .step_ok_o (step_ok),
    .is_first_o(is_first)
  );

  seq_lock_next u_next (
    .state_i   (state_q),
    .valid_i   (op_valid_i),
    .relock_i  (relock_i),
    .step_ok_i (step_ok),
    .is_first_i(is_first),
    .next_o    (state_d),
    .advance_o (advance),
    .fail_o    (fail)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= ST_IDLE;
    else       state_q <= state_d;
  end

  assign state_o = state_q;
  assign open_o  = (state_q == ST_OPEN);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    rst_i |=> state_q == ST_IDLE);
  assert_hold_no_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!op_valid_i && !relock_i) |=> $stable(state_q));
  assert_advance_one_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    advance |=> state_q == lock_st_e'($past(state_q) + 2'd1));
  assert_fail_target_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    fail |=> (state_q == ST_IDLE || state_q == ST_STEP1));
  assert_open_only_from_step2_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(open_o) |-> $past(state_q) == ST_STEP2);
  assert_open_ignores_ops_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_OPEN && !relock_i) |=> state_q == ST_OPEN);
  assert_exclusive_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({advance, fail}));
endmodule

// File: tb/seq_lock_tb.sv
module seq_lock_tb;
  logic clk = 0, rst = 1, vld = 0, dir = 0, rl = 0;
  logic [5:0] val = 0;
  logic open_w;
  logic [1:0] st;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  seq_lock u_dut (.clk_i(clk), .rst_i(rst), .op_valid_i(vld), .dir_i(dir),
                  .value_i(val), .relock_i(rl), .open_o(open_w), .state_o(st));

  task automatic check(string req, logic [1:0] exp);
    n_chk++;
    if (st !== exp || open_w !== (exp == 2'd3)) begin
      n_bad++;
      $display("FAIL %s: state=%0d open=%0b expected state=%0d open=%0b",
               req, st, open_w, exp, exp == 2'd3);
    end
  endtask

  // drive on negedge, sample on following negedge
  task automatic op(logic d, logic [5:0] v);
    vld = 1; dir = d; val = v;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    do_reset(); check("R1", 2'd0);
    op(1, 13); check("R3", 2'd1);
    do_reset(); check("R1", 2'd0);
  endtask

  task automatic t_open();
    do_reset();
    op(1, 13); check("R3", 2'd1);
    idle(3);   check("R2", 2'd1);
    dir = 0; val = 22; idle(1); check("R2", 2'd1);
    op(0, 22); check("R4", 2'd2);
    op(1, 3);  check("R5", 2'd3);
    check("R8", 2'd3);
  endtask

  task automatic t_open_hold();
    op(1, 13); check("R9", 2'd3);
    op(0, 5);  check("R9", 2'd3);
    idle(4);   check("R9", 2'd3);
    rl = 1; @(negedge clk); rl = 0;
    check("R9", 2'd0);
  endtask

  task automatic t_wrong();
    do_reset();
    op(0, 13); check("R6", 2'd0);
    op(1, 13); op(1, 22); check("R6", 2'd0);
    op(1, 13); op(0, 22); op(1, 4); check("R6", 2'd0);
    op(1, 13); op(1, 13); check("R6", 2'd1);
    op(0, 22); op(1, 13); check("R6", 2'd1);
    rl = 1; @(negedge clk); rl = 0; check("R9", 2'd1);
  endtask

  task automatic t_order();
    do_reset();
    op(0, 22); op(1, 13); op(1, 3); check("R7", 2'd0);
    do_reset();
    op(1, 3); op(0, 22); op(1, 13); check("R7", 2'd1);
    do_reset();
    op(1, 13); op(1, 3); op(0, 22); check("R7", 2'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_open();
    t_open_hold();
    t_wrong();
    t_order();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule